// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each 32-bit virtual address into one of five segments: the user segment, a kernel segment with a fixed physical mapping that is cached, a second fixed-mapped kernel segment that is uncached, a supervisor segment that goes through the page tables, and a kernel segment that also goes through the page tables. For the two fixed-mapped kernel segments it produces the physical address at once, with read and write permission. For the segments that go through the page tables it raises a lookup request toward an external translation buffer. An access made from a privilege level that the segment does not allow returns a bad-address code, with no translation.

The block has a guest mode. When it is enabled, two windows inside the user segment are treated as kernel segments for classification. The lower window behaves like the cached fixed-mapped kernel segment. The upper window behaves like the supervisor segment that goes through the page tables. Any lookup request still carries the address exactly as it arrived. Each input strobe yields one registered result one cycle later, marked by `out_valid`.

Top module: `vaddr_seg_decode`

## Requirements
- R1: While reset is asserted and afterwards until the first strobe, `out_valid`, `lookup_req`, `perm`, `status` and `paddr` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `lookup_req` is never high without `out_valid`.
- R3: An address below 0x80000000 (outside the guest windows) with `err_level` set returns `paddr` equal to `vaddr`, `perm`=2'b11 (bit 1 is read, bit 0 is write) and `status`=2'b00 (match), for any privilege.
- R4: An address below 0x80000000 (outside the guest windows) with `err_level` clear raises `lookup_req`, with `lookup_addr`=`vaddr`, `status`=2'b10 (lookup pending), `perm`=0 and `paddr`=0, for any privilege.
- R5: An address in 0x80000000..0x9FFFFFFF in kernel mode (`priv`=2'b10) returns `paddr`=`vaddr`-0x80000000, `perm`=2'b11 and match status.
- R6: An address in 0xA0000000..0xBFFFFFFF in kernel mode returns `paddr`=`vaddr`-0xA0000000, `perm`=2'b11 and match status.
- R7: An address in 0xC0000000..0xDFFFFFFF raises a lookup in supervisor (`priv`=2'b01) or kernel mode. An address at or above 0xE0000000 raises a lookup only in kernel mode. In both cases `lookup_addr`=`vaddr` and `status`=2'b10.
- R8: A privilege violation returns `status`=2'b01 (bad address), with `perm`=0, `paddr`=0 and no lookup. Codes 2'b00 and 2'b11 of `priv` count as user mode.
- R9: With `guest_en` set, an address in 0x40000000..0x5FFFFFFF is treated as `vaddr`+0x40000000. In kernel mode it yields `paddr`=`vaddr`-0x40000000. In any other mode it is a bad address. `err_level` has no effect on this window.
- R10: With `guest_en` set, an address in 0x60000000..0x7FFFFFFF is treated as the supervisor mapped segment. In supervisor or kernel mode it raises a lookup with the unshifted `vaddr`. In user mode it is a bad address.
- R11: With `guest_en` clear, addresses 0x40000000..0x7FFFFFFF follow R3 and R4 like the rest of the user segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address strobe |
| vaddr | input | 32 | Virtual address |
| priv | input | 2 | Privilege level: 00 user, 01 supervisor, 10 kernel, 11 user |
| err_level | input | 1 | Error-level status flag |
| guest_en | input | 1 | Guest-mode enable |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| paddr | output | 32 | Physical address for unmapped accesses |
| perm | output | 2 | Permission: bit 1 read, bit 0 write |
| lookup_req | output | 1 | Translation buffer lookup request |
| lookup_addr | output | 32 | Unshifted address carried with the lookup |
| status | output | 2 | 00 match, 01 bad address, 10 lookup pending |

## Verification
The guest-window remap and the error-level flag can both apply to the same access. With `err_level` set and `guest_en` set, an address in the lower guest window is decoded through the remap and not through the user-segment bypass. An address in the upper window is decoded as a mapped lookup that keeps its unshifted address. The bench drives all four combinations of the two flags on both windows, in each privilege level, and also mixes them at random. It judges each result against a reference model that is written from address ranges rather than bit slices.

// File: rtl/vaddr_seg_decode.sv
module vaddr_seg_decode #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] vaddr,
  input  logic [1:0]  priv,
  input  logic        err_level,
  input  logic        guest_en,
  output logic        out_valid,
  output logic [31:0] paddr,
  output logic [1:0]  perm,
  output logic        lookup_req,
  output logic [31:0] lookup_addr,
  output logic [1:0]  status
);
  localparam logic [1:0] ST_MATCH = 2'b00;
  localparam logic [1:0] ST_BAD   = 2'b01;
  localparam logic [1:0] ST_PEND  = 2'b10;
  localparam logic [31:0] GUEST_LO_SHIFT = 32'h4000_0000;
  localparam logic [31:0] GUEST_HI_SHIFT = 32'h6000_0000;

  logic        win_lo, win_hi, is_kern, is_sup;
  logic [31:0] eaddr;
  logic [31:0] n_paddr;
  logic [1:0]  n_perm, n_status;
  logic        n_req;

  assign win_lo  = guest_en && (vaddr[31:29] == 3'b010);
  assign win_hi  = guest_en && (vaddr[31:29] == 3'b011);
  assign eaddr   = win_lo ? vaddr + GUEST_LO_SHIFT :
                   win_hi ? vaddr + GUEST_HI_SHIFT : vaddr;
  assign is_kern = (priv == 2'b10);
  assign is_sup  = (priv == 2'b01) || is_kern;

  always_comb begin
    n_paddr  = '0;
    n_perm   = '0;
    n_req    = 1'b0;
    n_status = ST_BAD;
    unique casez (eaddr[31:29])
      3'b0??: begin
        if (err_level) begin
          n_paddr  = eaddr;
          n_perm   = 2'b11;
          n_status = ST_MATCH;
        end else begin
          n_req    = 1'b1;
          n_status = ST_PEND;
        end
      end
      3'b100, 3'b101: begin
        if (is_kern) begin
          n_paddr  = {3'b000, eaddr[28:0]};
          n_perm   = 2'b11;
          n_status = ST_MATCH;
        end
      end
      3'b110: begin
        if (is_sup) begin
          n_req    = 1'b1;
          n_status = ST_PEND;
        end
      end
      default: begin
        if (is_kern) begin
          n_req    = 1'b1;
          n_status = ST_PEND;
        end
      end
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          paddr       <= '0;
          perm        <= '0;
          lookup_req  <= 1'b0;
          lookup_addr <= '0;
          status      <= ST_MATCH;
        end else begin
          out_valid  <= in_valid;
          lookup_req <= in_valid && n_req;
          if (in_valid) begin
            paddr       <= n_paddr;
            perm        <= n_perm;
            lookup_addr <= n_req ? vaddr : '0;
            status      <= n_status;
          end
        end
      end
    end else begin : g_comb
      assign out_valid   = in_valid;
      assign paddr       = n_paddr;
      assign perm        = n_perm;
      assign lookup_req  = in_valid && n_req;
      assign lookup_addr = n_req ? vaddr : '0;
      assign status      = n_status;
    end
  endgenerate
endmodule

// File: rtl/vaddr_seg_decode_chk.sv
module vaddr_seg_decode_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] vaddr,
  input logic        out_valid,
  input logic [31:0] paddr,
  input logic [1:0]  perm,
  input logic        lookup_req,
  input logic [31:0] lookup_addr,
  input logic [1:0]  status
);
  generate
    if (OUT_REG) begin : g_lat
      assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    end
  endgenerate

  assert_req_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_req |-> out_valid);

  assert_bad_is_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && status == 2'b01) |-> (perm == 2'b00 && !lookup_req && paddr == 32'h0));

  assert_pending_no_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_req |-> (status == 2'b10 && perm == 2'b00));

  assert_match_full_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && status == 2'b00) |-> (perm == 2'b11 && !lookup_req));

  assert_lookup_not_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_req |-> (lookup_addr[31:29] != 3'b100 && lookup_addr[31:29] != 3'b101));

  assert_status_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> status != 2'b11);
endmodule

bind vaddr_seg_decode vaddr_seg_decode_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vaddr(vaddr),
  .out_valid(out_valid), .paddr(paddr), .perm(perm), .lookup_req(lookup_req),
  .lookup_addr(lookup_addr), .status(status)
);

// File: tb/vaddr_seg_decode_test.sv
module vaddr_seg_decode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  priv = '0;
  logic        err_level = 1'b0;
  logic        guest_en = 1'b0;
  logic        out_valid, lookup_req;
  logic [31:0] paddr, lookup_addr;
  logic [1:0]  perm, status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vaddr_seg_decode uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vaddr(vaddr), .priv(priv),
    .err_level(err_level), .guest_en(guest_en), .out_valid(out_valid),
    .paddr(paddr), .perm(perm), .lookup_req(lookup_req),
    .lookup_addr(lookup_addr), .status(status)
  );

  // Reference model: returns {req, status, perm, paddr, laddr}
  function automatic logic [68:0] model(input logic [31:0] va, input logic [1:0] pv,
                                        input logic el, input logic ge);
    logic [63:0] a;
    logic kern, sup, req;
    logic [1:0] st, pm;
    logic [31:0] pa, la;
    a = {32'h0, va};
    kern = (pv == 2'b10);
    sup  = (pv == 2'b01) || (pv == 2'b10);
    req = 0; st = 2'b01; pm = 0; pa = 0; la = 0;
    if (ge && a >= 64'h4000_0000 && a < 64'h6000_0000) begin
      if (kern) begin st = 2'b00; pm = 2'b11; pa = va - 32'h4000_0000; end
    end else if (ge && a >= 64'h6000_0000 && a < 64'h8000_0000) begin
      if (sup) begin req = 1; st = 2'b10; la = va; end
    end else if (a < 64'h8000_0000) begin
      if (el) begin st = 2'b00; pm = 2'b11; pa = va; end
      else begin req = 1; st = 2'b10; la = va; end
    end else if (a < 64'hA000_0000) begin
      if (kern) begin st = 2'b00; pm = 2'b11; pa = va - 32'h8000_0000; end
    end else if (a < 64'hC000_0000) begin
      if (kern) begin st = 2'b00; pm = 2'b11; pa = va - 32'hA000_0000; end
    end else if (a < 64'hE000_0000) begin
      if (sup) begin req = 1; st = 2'b10; la = va; end
    end else begin
      if (kern) begin req = 1; st = 2'b10; la = va; end
    end
    return {req, st, pm, pa, la};
  endfunction

  task automatic check(input string tag, input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] va, input logic [1:0] pv,
                       input logic el, input logic ge);
    @(negedge clk);
    vaddr = va; priv = pv; err_level = el; guest_en = ge; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin
      failures++;
      $display("FAIL R2 out_valid actual=%b expected=1", out_valid);
    end
    check(tag, {lookup_req, status, perm, paddr, lookup_addr}, model(va, pv, el, ge));
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || lookup_req !== 1'b0) begin
      failures++;
      $display("FAIL R2 idle actual=%b%b expected=00", out_valid, lookup_req);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, lookup_req, status, perm, paddr, lookup_addr},
          {1'b0, 69'h0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {out_valid, lookup_req, status, perm, paddr, lookup_addr},
          {1'b0, 69'h0});

    apply("R3 user bypass", 32'h1234_5678, 2'b00, 1'b1, 1'b0);
    apply("R3 user bypass top", 32'h7FFF_FFFF, 2'b10, 1'b1, 1'b0);
    apply("R4 user lookup", 32'h0000_1000, 2'b00, 1'b0, 1'b0);
    apply("R5 kseg0 kernel", 32'h8000_0040, 2'b10, 1'b0, 1'b0);
    apply("R5 kseg0 edge", 32'h9FFF_FFFF, 2'b10, 1'b0, 1'b0);
    apply("R6 kseg1 kernel", 32'hA000_0000, 2'b10, 1'b1, 1'b0);
    apply("R6 kseg1 edge", 32'hBFFF_FFFC, 2'b10, 1'b0, 1'b0);
    apply("R7 sseg super", 32'hC000_0000, 2'b01, 1'b0, 1'b0);
    apply("R7 kseg3 kernel", 32'hFFFF_FFFF, 2'b10, 1'b0, 1'b0);
    apply("R8 kseg0 user", 32'h8000_0000, 2'b00, 1'b1, 1'b0);
    apply("R8 kseg1 super", 32'hA000_1000, 2'b01, 1'b0, 1'b0);
    apply("R8 sseg user", 32'hDFFF_FFFF, 2'b11, 1'b0, 1'b0);
    apply("R8 kseg3 super", 32'hE000_0000, 2'b01, 1'b0, 1'b0);
    for (int p = 0; p < 4; p++) begin
      for (int f = 0; f < 2; f++) begin
        apply("R9 guest low win", 32'h4000_0000, p[1:0], f[0], 1'b1);
        apply("R9 guest low win top", 32'h5FFF_FFF0, p[1:0], f[0], 1'b1);
        apply("R10 guest high win", 32'h6000_0004, p[1:0], f[0], 1'b1);
        apply("R10 guest high win top", 32'h7FFF_FFFF, p[1:0], f[0], 1'b1);
        apply("R11 guest off low", 32'h4800_0000, p[1:0], f[0], 1'b0);
        apply("R11 guest off high", 32'h6800_0000, p[1:0], f[0], 1'b0);
      end
    end
    apply("R3 below guest win", 32'h3FFF_FFFF, 2'b00, 1'b1, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] va;
      va = $urandom;
      if (i % 3 == 0) va[31:29] = 3'($urandom_range(2, 3));
      apply("R3-R11 random mix", va, 2'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule